// File: doc/BRIEF.md
# 100BASE-TX Receive Code-Group Decoder

This block sits after descrambling and code-group alignment in a 100BASE-TX receive path. It accepts one aligned 5-bit code-group per clock and turns the stream into 4-bit nibbles, with a data-valid flag and an error flag, for a media-independent receive interface. It finds the start of a frame from the J/K delimiter pair and the end of a frame from the T/R pair. It marks code-groups that are not legal inside a frame. It also catches a false start on an idle line: the error nibble is held until the line has been quiet long enough.

Every decision is made one code-group late, so the decoder can see the following code-group. That is how it recognises the J/K and T/R pairs. The result for the code-group sampled at clock edge k appears on the outputs after edge k+1. A bypass input skips decoding and sends the raw code-group straight to the output, with the same latency.

Top module: `rxcg_decoder`

## Requirements
- R1: Inside a frame, each data code-group drives `dat_o` to {0, nibble} with `dv_o`=1 and `er_o`=0. The table is: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. In normal mode bit 4 of `dat_o` is always 0.
- R2: On an idle line, J (11000) followed at once by K (10001) starts a frame. Both code-groups come out as nibble 0101 with `dv_o`=1. The result for the code-group sampled at edge k appears after edge k+1.
- R3: Inside a frame, T (01101) followed at once by R (00111) ends the frame. Both code-groups come out with `dv_o`=0, `er_o`=0 and nibble 0000, and the line is then idle.
- R4: Inside a frame, a code-group that is neither data nor the T/R pair, and is not IDLE, gives `dv_o`=1, `er_o`=1 and nibble 1110 for that code-group only. The frame continues.
- R5: On an idle line, a non-IDLE code-group that does not begin a J/K pair is a bad start delimiter. That code-group and every following one give `er_o`=1, `dv_o`=0 and nibble 1110. This lasts until two consecutive IDLE (11111) code-groups have arrived. The second of those IDLEs is output clean, and the line is idle again.
- R6: An IDLE inside a frame ends the frame early. That code-group gives `dv_o`=0, `er_o`=1 and nibble 1110, and the line is idle afterwards.
- R7: While `bypass_i` is high, `dat_o` carries the raw 5-bit code-group with the same latency, `dv_o` and `er_o` stay 0, and any frame or error state is cancelled.
- R8: While reset is asserted, `dat_o`, `dv_o` and `er_o` are 0.
- R9: On an idle line, IDLE code-groups give all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Code-group clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cg_i | input | 5 | Aligned received code-group, one per clock |
| bypass_i | input | 1 | Pass raw code-groups without decoding |
| dat_o | output | 5 | Nibble in bits 3:0 (bit 4 is 0), or the raw code-group in bypass |
| dv_o | output | 1 | Receive data valid |
| er_o | output | 1 | Receive error |

## Verification
Some properties are checked on every cycle. An asserted error flag always carries the 1110 nibble. A rising data-valid always carries the 0101 start nibble. Bypass keeps both flags low, and normal mode keeps bit 4 clear. The error-recovery counter stays below its limit. The bench scenarios cover the rest, because it depends on the order of code-groups: the full decode table, T/R and J/K pairing with the lookahead, an early IDLE, a J without K, and the IDLE run that has to be counted again when a non-IDLE breaks it.

// File: rtl/rxcg_pkg.sv
package rxcg_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_SOF = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_ERR = 4'b1110;

  typedef enum logic [2:0] {ST_IDLE, ST_K, ST_FRAME, ST_R, ST_BAD} rx_state_e;

  typedef struct packed {
    logic             is_data;
    logic             is_idle;
    logic             is_j;
    logic             is_k;
    logic             is_t;
    logic             is_r;
    logic [NIB_W-1:0] nib;
  } cg_info_t;
endpackage

// File: rtl/rxcg_lookup.sv
module rxcg_lookup
  import rxcg_pkg::*;
(
  input  logic [CG_W-1:0] cg_i,
  output cg_info_t        info_o
);
  always_comb begin
    info_o         = '0;
    info_o.is_idle = (cg_i == CG_IDLE);
    info_o.is_j    = (cg_i == CG_J);
    info_o.is_k    = (cg_i == CG_K);
    info_o.is_t    = (cg_i == CG_T);
    info_o.is_r    = (cg_i == CG_R);
    info_o.is_data = 1'b1;
    case (cg_i)
      5'b11110: info_o.nib = 4'h0;
      5'b01001: info_o.nib = 4'h1;
      5'b10100: info_o.nib = 4'h2;
      5'b10101: info_o.nib = 4'h3;
      5'b01010: info_o.nib = 4'h4;
      5'b01011: info_o.nib = 4'h5;
      5'b01110: info_o.nib = 4'h6;
      5'b01111: info_o.nib = 4'h7;
      5'b10010: info_o.nib = 4'h8;
      5'b10011: info_o.nib = 4'h9;
      5'b10110: info_o.nib = 4'hA;
      5'b10111: info_o.nib = 4'hB;
      5'b11010: info_o.nib = 4'hC;
      5'b11011: info_o.nib = 4'hD;
      5'b11100: info_o.nib = 4'hE;
      5'b11101: info_o.nib = 4'hF;
      default: begin
        info_o.is_data = 1'b0;
        info_o.nib     = '0;
      end
    endcase
  end
endmodule

// File: rtl/rxcg_fsm.sv
module rxcg_fsm
  import rxcg_pkg::*;
#(
  parameter int QUIET_MIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  cg_info_t         cur_i,
  input  cg_info_t         nxt_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             dv_o,
  output logic             er_o
);
  localparam int QW = $clog2(QUIET_MIN + 1);

  rx_state_e      st_q, st_d;
  logic [QW-1:0]  q_q, q_d;

  always_comb begin
    st_d  = st_q;
    q_d   = q_q;
    dv_o  = 1'b0;
    er_o  = 1'b0;
    nib_o = '0;
    if (bypass_i) begin
      st_d = ST_IDLE;
      q_d  = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cur_i.is_idle) begin
            st_d = ST_IDLE;
          end else if (cur_i.is_j && nxt_i.is_k) begin
            dv_o  = 1'b1;
            nib_o = NIB_SOF;
            st_d  = ST_K;
          end else begin
            er_o  = 1'b1;
            nib_o = NIB_ERR;
            st_d  = ST_BAD;
            q_d   = '0;
          end
        end
        ST_K: begin
          dv_o  = 1'b1;
          nib_o = NIB_SOF;
          st_d  = ST_FRAME;
        end
        ST_FRAME: begin
          if (cur_i.is_t && nxt_i.is_r) begin
            st_d = ST_R;
          end else if (cur_i.is_idle) begin
            // early end of stream
            er_o  = 1'b1;
            nib_o = NIB_ERR;
            st_d  = ST_IDLE;
          end else if (cur_i.is_data) begin
            dv_o  = 1'b1;
            nib_o = cur_i.nib;
          end else begin
            dv_o  = 1'b1;
            er_o  = 1'b1;
            nib_o = NIB_ERR;
          end
        end
        ST_R: st_d = ST_IDLE;
        ST_BAD: begin
          if (cur_i.is_idle && (int'(q_q) + 1 >= QUIET_MIN)) begin
            st_d = ST_IDLE;
            q_d  = '0;
          end else begin
            er_o  = 1'b1;
            nib_o = NIB_ERR;
            q_d   = cur_i.is_idle ? q_q + 1'b1 : '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      q_q  <= '0;
    end else begin
      st_q <= st_d;
      q_q  <= q_d;
    end
  end

  AST_QUIET_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BAD) |-> (int'(q_q) < QUIET_MIN)); // R5
endmodule

// File: rtl/rxcg_decoder.sv
module rxcg_decoder
  import rxcg_pkg::*;
#(
  parameter int QUIET_MIN = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CG_W-1:0] cg_i,
  input  logic            bypass_i,
  output logic [CG_W-1:0] dat_o,
  output logic            dv_o,
  output logic            er_o
);
  logic [CG_W-1:0]  hold_q;
  cg_info_t         cur_info, nxt_info;
  logic [NIB_W-1:0] nib_d;
  logic             dv_d, er_d;

  // lookahead: decide on hold_q while seeing cg_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= CG_IDLE;
    else         hold_q <= cg_i;
  end

  rxcg_lookup u_cur (.cg_i(hold_q), .info_o(cur_info));
  rxcg_lookup u_nxt (.cg_i(cg_i),   .info_o(nxt_info));

  rxcg_fsm #(.QUIET_MIN(QUIET_MIN)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .cur_i    (cur_info),
    .nxt_i    (nxt_info),
    .nib_o    (nib_d),
    .dv_o     (dv_d),
    .er_o     (er_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
    end else if (bypass_i) begin
      dat_o <= hold_q;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
    end else begin
      dat_o <= {{(CG_W-NIB_W){1'b0}}, nib_d};
      dv_o  <= dv_d;
      er_o  <= er_d;
    end
  end

  AST_ER_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_o |-> (dat_o == {1'b0, NIB_ERR})); // R4
  AST_SOF_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dv_o) |-> (dat_o == {1'b0, NIB_SOF})); // R2
  AST_BYPASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass_i) |-> (!dv_o && !er_o)); // R7
  AST_NIB_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bypass_i) |-> !dat_o[CG_W-1]); // R1
endmodule

// File: tb/sim_rxcg_decoder.sv
module sim_rxcg_decoder;
  localparam int QUIET = 2;
  localparam logic [4:0] IDL = 5'b11111, J = 5'b11000, K = 5'b10001, T = 5'b01101, R = 5'b00111;
  localparam logic [4:0] CODES [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
    5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic clk = 0, rst_n = 0, byp = 0;
  logic [4:0] cg = IDL;
  logic [4:0] dat;
  logic dv, er;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxcg_decoder #(.QUIET_MIN(QUIET)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cg_i(cg), .bypass_i(byp),
    .dat_o(dat), .dv_o(dv), .er_o(er));

  // reference model state
  int ms = 0, mq = 0;
  logic [4:0] mprev = IDL;
  logic [4:0] e_dat = 0;
  logic e_dv = 0, e_er = 0;
  string e_tag = "R8";

  function automatic int dec(logic [4:0] c);
    for (int i = 0; i < 16; i++) if (CODES[i] == c) return i;
    return -1;
  endfunction

  task automatic compare();
    checks++;
    if (dat !== e_dat || dv !== e_dv || er !== e_er) begin
      errors++;
      $display("FAIL %s: got dat=%b dv=%b er=%b exp dat=%b dv=%b er=%b",
               e_tag, dat, dv, er, e_dat, e_dv, e_er);
    end
  endtask

  task automatic predict(input logic [4:0] c, input logic b);
    int v;
    v = dec(mprev);
    e_dat = 0; e_dv = 0; e_er = 0;
    if (b) begin
      e_dat = mprev; e_tag = "R7"; ms = 0; mq = 0;
    end else begin
      case (ms)
        0: begin
          if (mprev == IDL) e_tag = "R9";
          else if (mprev == J && c == K) begin e_dv = 1; e_dat = 5'd5; ms = 1; e_tag = "R2"; end
          else begin e_er = 1; e_dat = 5'd14; ms = 4; mq = 0; e_tag = "R5"; end
        end
        1: begin e_dv = 1; e_dat = 5'd5; ms = 2; e_tag = "R2"; end
        2: begin
          if (mprev == T && c == R) begin ms = 3; e_tag = "R3"; end
          else if (mprev == IDL) begin e_er = 1; e_dat = 5'd14; ms = 0; e_tag = "R6"; end
          else if (v >= 0) begin e_dv = 1; e_dat = 5'(v); e_tag = "R1"; end
          else begin e_dv = 1; e_er = 1; e_dat = 5'd14; e_tag = "R4"; end
        end
        3: begin ms = 0; e_tag = "R3"; end
        default: begin
          e_tag = "R5";
          if (mprev == IDL) begin
            mq++;
            if (mq >= QUIET) begin ms = 0; mq = 0; end
            else begin e_er = 1; e_dat = 5'd14; end
          end else begin
            mq = 0; e_er = 1; e_dat = 5'd14;
          end
        end
      endcase
    end
    mprev = c;
  endtask

  task automatic send(input logic [4:0] c, input logic b = 0);
    @(negedge clk);
    compare();
    cg = c; byp = b;
    predict(c, b);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) send(IDL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R8 reset state
    rst_n = 1;
    idles(3);                                   // R9
    send(J); send(K);                           // R2
    for (int i = 0; i < 16; i++) send(CODES[i]); // R1
    send(T); send(R); idles(3);                 // R3
    send(J); send(K); send(CODES[3]); send(5'b00000); send(CODES[7]); // R4
    send(J); send(T); send(CODES[1]); send(T); send(R); idles(2);     // R4 lone J/T
    send(J); send(K); send(CODES[9]); send(IDL); idles(2);            // R6
    send(CODES[5]); send(K); send(IDL); send(CODES[9]); send(IDL); send(IDL); idles(2); // R5
    send(J); send(CODES[2]); send(IDL); send(IDL); idles(1);          // R5 J without K
    send(J); send(K); send(CODES[4]); send(T); send(R); idles(2);     // after recovery
    send(J); send(K); send(CODES[6]);
    send(5'b10101, 1); send(5'b00011, 1); send(J, 1); send(IDL, 1);   // R7 mid-frame
    idles(3); send(CODES[8]); idles(3);                               // R9 then R5 after bypass
    send(5'b01010, 1); send(5'b11111, 1); idles(3);                   // R7
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule